// File: doc/BRIEF.md
# Wake-up Timer with Prescaled Counter and Compare Interrupt

This peripheral counts ticks from one of four tick sources and raises a sticky flag, plus an optional interrupt, once a programmed number of counts has elapsed since the threshold was loaded. It is meant for timed wake-up, where software arms a single deadline and then waits for the interrupt. Two fixed prescalers sit between the chosen source and the counter. One divides by 32 and the other by 512, and enabling both divides by 16384.

Software uses a 32-bit register port clocked by the bus clock. The counter runs on its own clock. Each tick source is a one-cycle enable strobe in that clock domain. A new threshold crosses into the counter domain over a toggle request/acknowledge pair. A busy status bit stays set for as long as a crossing is in flight or a later write is queued behind one. Loading a threshold restarts the count and both prescalers, so the flag fires exactly threshold × division source ticks later.

Top module: `rtc_wakeup_timer`

## Requirements
- R1: After reset the control, status and threshold registers all read 0, the irq output is 0 and the counter is cleared.
- R2: The control register sits at offset 0x04. Bit 31 starts the counter, bit 15 arms the compare function, bit 14 enables the interrupt, bits 13:12 pick the tick source, bit 11 enables divide-by-512 and bit 10 enables divide-by-32. Every field reads back as written while the counter is stopped.
- R3: The effective division is 1 with no divider enabled, 32 or 512 with one enabled, and 16384 with both. The flag sets after exactly threshold × division ticks of the selected source, and it stays clear one tick earlier.
- R4: Only ticks on the source picked by bits 13:12 are counted. Source index 1 is reserved, and selecting it never advances the counter.
- R5: While bit 31 reads 1, a control write leaves bits 13:10 unchanged and updates the other bits.
- R6: With bit 15 set, the flag (status bit 13, at offset 0x08) sets when the count since the last threshold load reaches the threshold. It fires once per load. With bit 15 clear, no flag is raised.
- R7: Writing 1 to status bit 13 clears the flag. Writing 0 there leaves it unchanged.
- R8: irq equals the flag ANDed with control bit 14, delayed by one bus clock.
- R9: A write to the threshold register (offset 0x10) sets status bit 17 from the next cycle until the value has reached the counter domain. The threshold register reads back the last value written.
- R10: A threshold write that arrives while bit 17 is set is held and sent once the current transfer ends. The latest queued value wins.
- R11: A threshold of 0 disarms the compare, so no flag is raised however many ticks arrive.
- R12: With bit 31 clear the counter does not advance and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| cclk | input | 1 | Counter-domain clock |
| crst | input | 1 | Synchronous active-high reset, counter domain |
| src_tick | input | 4 | One-cycle tick strobes of the four sources, cclk domain |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
A table of configurations drives each tick source and each division setting, which are 1, 32, 512 and 16384. Each setting runs twice: once with one tick fewer than the threshold needs and once with exactly enough. This separates a correct prescaler chain from one that is off by a stage or off by one. Two rows tick a source that is not selected or select the reserved source. These rows show whether the source multiplexer and the reserved-index guard work. Directed tests then change the configuration while the counter runs, issue back-to-back threshold writes, write a zero threshold, and run with the compare function disabled, the counter stopped or the interrupt masked. Each of these has a distinct expected flag and irq value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int SRC_N   = 4;
  localparam int SEL_W   = $clog2(SRC_N);

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_THR  = 5'h10;

  localparam int BIT_RUN  = 31;
  localparam int BIT_ARM  = 15;
  localparam int BIT_IE   = 14;
  localparam int BIT_SEL  = 12;
  localparam int BIT_D512 = 11;
  localparam int BIT_D32  = 10;
  localparam int BIT_BUSY = 17;
  localparam int BIT_FLAG = 13;

  localparam logic [SEL_W-1:0] SRC_RESERVED = SEL_W'(1);

  typedef struct packed {
    logic             run;
    logic             arm;
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic             d512;
    logic             d32;
  } ctrl_t;
endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32,
  localparam int CW = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic tick_i,
  output logic tick_o
);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assign tick_o = en ? (tick_i & wrap) : tick_i;
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_LO = 32,
  parameter int DIV_HI = 512
) (
  input  logic             cclk,
  input  logic             crst,
  input  ctrl_t            cfg_i,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             req_tgl_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             ack_tgl_o,
  output logic             hit_tgl_o
);
  localparam int NSTAGE = 2;
  localparam int STAGE_DIV [NSTAGE] = '{DIV_LO, DIV_HI};

  logic [$bits(ctrl_t)-1:0] cfg_raw;
  ctrl_t                    cfg_s;
  logic                     req_s, req_d, load;
  logic                     run_c;
  logic [NSTAGE:0]          tk;
  logic [NSTAGE-1:0]        st_en;
  logic [CNT_W-1:0]         count, thr_c;
  logic                     armed;

  rtc_sync2 #(.W($bits(ctrl_t))) u_cfg_sync (
    .clk(cclk), .rst(crst), .d(cfg_i), .q(cfg_raw)
  );
  rtc_sync2 #(.W(1)) u_req_sync (
    .clk(cclk), .rst(crst), .d(req_tgl_i), .q(req_s)
  );

  assign cfg_s = ctrl_t'(cfg_raw);
  assign load  = req_s ^ req_d;
  assign run_c = cfg_s.run && (cfg_s.sel != SRC_RESERVED);
  assign st_en = {cfg_s.d512, cfg_s.d32};
  assign tk[0] = run_c & src_tick[cfg_s.sel];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    rtc_prescaler #(.DIV(STAGE_DIV[g])) u_pre (
      .clk(cclk), .rst(crst), .clr(load | ~run_c), .en(st_en[g]),
      .tick_i(tk[g]), .tick_o(tk[g+1])
    );
  end

  always_ff @(posedge cclk) begin
    if (crst) begin
      req_d     <= 1'b0;
      ack_tgl_o <= 1'b0;
      count     <= '0;
      thr_c     <= '0;
      armed     <= 1'b0;
      hit_tgl_o <= 1'b0;
    end else begin
      req_d     <= req_s;
      ack_tgl_o <= req_s;
      if (load) begin
        count <= '0;
        thr_c <= thr_i;
        armed <= (thr_i != '0);
      end else if (tk[NSTAGE]) begin
        count <= count + 1'b1;
        if (armed && cfg_s.arm && ((count + 1'b1) == thr_c)) begin
          hit_tgl_o <= ~hit_tgl_o;
          armed     <= 1'b0;
        end
      end
    end
  end

  AST_ZERO_DISARMS: assert property (@(posedge cclk) disable iff (crst)
    (thr_c == '0 && !load) |=> $stable(hit_tgl_o)); // R11
  AST_RESERVED_HOLD: assert property (@(posedge cclk) disable iff (crst)
    (cfg_s.sel == SRC_RESERVED && !load) |=> $stable(count)); // R4
  AST_STOPPED_HOLD: assert property (@(posedge cclk) disable iff (crst)
    (!cfg_s.run && !load) |=> $stable(count)); // R12
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output ctrl_t             cfg_o,
  output logic              req_tgl_o,
  output logic [CNT_W-1:0]  thr_xfer_o,
  input  logic              ack_tgl_i,
  input  logic              hit_tgl_i
);
  logic             ack_s, hit_s, hit_d;
  logic             inflight, busy;
  logic             wr_ctrl, wr_stat, wr_thr;
  logic [CNT_W-1:0] thr_sw, pend_d;
  logic             pend_v;
  logic             flag;

  rtc_sync2 #(.W(1)) u_ack_sync (.clk(clk), .rst(rst), .d(ack_tgl_i), .q(ack_s));
  rtc_sync2 #(.W(1)) u_hit_sync (.clk(clk), .rst(rst), .d(hit_tgl_i), .q(hit_s));

  assign inflight = req_tgl_o ^ ack_s;
  assign busy     = inflight | pend_v;
  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
  assign wr_thr   = bus_we && (bus_addr == OFS_THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o      <= '0;
      thr_sw     <= '0;
      pend_v     <= 1'b0;
      pend_d     <= '0;
      req_tgl_o  <= 1'b0;
      thr_xfer_o <= '0;
      flag       <= 1'b0;
      hit_d      <= 1'b0;
      irq_o      <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_o.run <= bus_wdata[BIT_RUN];
        cfg_o.arm <= bus_wdata[BIT_ARM];
        cfg_o.ie  <= bus_wdata[BIT_IE];
        if (!cfg_o.run) begin
          cfg_o.sel  <= bus_wdata[BIT_SEL +: SEL_W];
          cfg_o.d512 <= bus_wdata[BIT_D512];
          cfg_o.d32  <= bus_wdata[BIT_D32];
        end
      end

      if (wr_thr) begin
        thr_sw <= bus_wdata[CNT_W-1:0];
        if (!busy) begin
          thr_xfer_o <= bus_wdata[CNT_W-1:0];
          req_tgl_o  <= ~req_tgl_o;
        end else begin
          pend_v <= 1'b1;
          pend_d <= bus_wdata[CNT_W-1:0];
        end
      end else if (pend_v && !inflight) begin
        thr_xfer_o <= pend_d;
        req_tgl_o  <= ~req_tgl_o;
        pend_v     <= 1'b0;
      end

      hit_d <= hit_s;
      flag  <= (hit_s ^ hit_d) | (flag & ~(wr_stat & bus_wdata[BIT_FLAG]));
      irq_o <= flag & cfg_o.ie;

      case (bus_addr)
        OFS_CTRL: bus_rdata <= {cfg_o.run, 15'b0, cfg_o.arm, cfg_o.ie, cfg_o.sel,
                                cfg_o.d512, cfg_o.d32, 10'b0};
        OFS_STAT: bus_rdata <= {14'b0, busy, 3'b0, flag, 13'b0};
        OFS_THR:  bus_rdata <= DATA_W'(thr_sw);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    cfg_o.run |=> ($stable(cfg_o.sel) && $stable(cfg_o.d512) && $stable(cfg_o.d32))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_stat && bus_wdata[BIT_FLAG])) |=> flag); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !cfg_o.ie |=> !irq_o); // R8
  AST_XFER_STABLE: assert property (@(posedge clk) disable iff (rst)
    inflight |=> $stable(thr_xfer_o)); // R9
endmodule

// File: rtl/rtc_wakeup_timer.sv
module rtc_wakeup_timer
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_LO = 32,
  parameter int DIV_HI = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cclk,
  input  logic              crst,
  input  logic [SRC_N-1:0]  src_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t            cfg;
  logic             req_tgl, ack_tgl, hit_tgl;
  logic [CNT_W-1:0] thr_xfer;

  rtc_bus_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq),
    .cfg_o(cfg), .req_tgl_o(req_tgl), .thr_xfer_o(thr_xfer),
    .ack_tgl_i(ack_tgl), .hit_tgl_i(hit_tgl)
  );

  rtc_count_core #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_core (
    .cclk(cclk), .crst(crst), .cfg_i(cfg), .src_tick(src_tick),
    .req_tgl_i(req_tgl), .thr_i(thr_xfer), .ack_tgl_o(ack_tgl),
    .hit_tgl_o(hit_tgl)
  );
endmodule

// File: tb/sim_rtc_wakeup_timer.sv
module sim_rtc_wakeup_timer;
  logic        clk = 1'b0, cclk = 1'b0;
  logic        rst = 1'b1, crst = 1'b1;
  logic [3:0]  src_tick = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;

  localparam logic [4:0] A_CTRL = 5'h04, A_STAT = 5'h08, A_THR = 5'h10;
  localparam logic [31:0] FLAG_M = 32'h0000_2000;
  localparam logic [31:0] BUSY_M = 32'h0002_0000;

  always #2 clk = ~clk;
  always #4 cclk = ~cclk;

  rtc_wakeup_timer u0 (
    .clk(clk), .rst(rst), .cclk(cclk), .crst(crst), .src_tick(src_tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        d512;
    logic        d32;
    logic [31:0] thr;
    logic [15:0] ticks;
    logic [1:0]  src;
    logic        exp_flag;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 32'd5, 16'd4,     2'd0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 32'd5, 16'd5,     2'd0, 1'b1},
    '{2'd2, 1'b0, 1'b1, 32'd2, 16'd63,    2'd2, 1'b0},
    '{2'd2, 1'b0, 1'b1, 32'd2, 16'd64,    2'd2, 1'b1},
    '{2'd3, 1'b1, 1'b0, 32'd1, 16'd511,   2'd3, 1'b0},
    '{2'd3, 1'b1, 1'b0, 32'd1, 16'd512,   2'd3, 1'b1},
    '{2'd0, 1'b1, 1'b1, 32'd1, 16'd16383, 2'd0, 1'b0},
    '{2'd0, 1'b1, 1'b1, 32'd1, 16'd16384, 2'd0, 1'b1},
    '{2'd2, 1'b0, 1'b0, 32'd3, 16'd10,    2'd0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 32'd1, 16'd10,    2'd1, 1'b0}
  };

  function automatic logic [31:0] mk(input logic run, input logic arm, input logic ie,
                                     input logic [1:0] sel, input logic d512,
                                     input logic d32);
    return {run, 15'b0, arm, ie, sel, d512, d32, 10'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit done = 0;
    for (int i = 0; i < 100 && !done; i++) begin
      rd(A_STAT, s);
      if ((s & BUSY_M) == 0) done = 1;
    end
    check(req, {31'b0, done}, 32'd1);
  endtask

  task automatic tick(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge cclk);
      src_tick = 4'(1 << src);
    end
    @(negedge cclk);
    src_tick = '0;
  endtask

  task automatic flag_now(output logic f);
    logic [31:0] s;
    idle(30);
    rd(A_STAT, s);
    f = s[13];
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic f;
    idle(5);
    rst = 1'b0; crst = 1'b0;
    idle(2);

    // R1 reset state
    rd(A_CTRL, r); check("R1 ctrl", r, 32'h0);
    rd(A_STAT, r); check("R1 stat", r, 32'h0);
    rd(A_THR,  r); check("R1 thr",  r, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 readback with counter stopped
    wr(A_CTRL, mk(0, 1, 1, 2'd3, 1, 1));
    rd(A_CTRL, r); check("R2 ctrl readback", r, 32'h0000_FC00);

    // R5 lock while running
    wr(A_CTRL, 32'h8000_FC00);
    rd(A_CTRL, r); check("R5 start", r, 32'h8000_FC00);
    wr(A_CTRL, 32'h8000_0000);
    rd(A_CTRL, r); check("R5 locked fields", r, 32'h8000_3C00);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, r); check("R5 stop keeps fields", r, 32'h0000_3C00);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, r); check("R5 stopped rewrite", r, 32'h0);

    // R9 busy indication and readback
    wr(A_THR, 32'd7);
    rd(A_STAT, r); check("R9 busy set", r & BUSY_M, BUSY_M);
    wait_idle("R9 busy clears");
    rd(A_THR, r); check("R9 thr readback", r, 32'd7);

    // R3 / R4 table
    for (int v = 0; v < NVEC; v++) begin
      wr(A_CTRL, 32'h0);
      wr(A_CTRL, mk(0, 1, 1, VEC[v].sel, VEC[v].d512, VEC[v].d32));
      wr(A_STAT, FLAG_M);
      wr(A_THR, VEC[v].thr);
      wait_idle("R9 table idle");
      wr(A_CTRL, mk(1, 1, 1, VEC[v].sel, VEC[v].d512, VEC[v].d32));
      idle(10);
      tick(int'(VEC[v].src), int'(VEC[v].ticks));
      flag_now(f);
      check(v >= 8 ? "R4 source select" : "R3 division", {31'b0, f}, {31'b0, VEC[v].exp_flag});
      check("R8 irq follows flag", {31'b0, irq}, {31'b0, VEC[v].exp_flag});
    end

    // R10 back-to-back threshold writes, latest wins
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, mk(0, 1, 1, 2'd0, 0, 0));
    wr(A_STAT, FLAG_M);
    wr(A_CTRL, mk(1, 1, 1, 2'd0, 0, 0));
    idle(10);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_THR; bus_wdata = 32'd1;
    @(negedge clk);
    bus_wdata = 32'd6;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_THR, r); check("R10 latest readback", r, 32'd6);
    wait_idle("R10 idle");
    idle(10);
    tick(0, 5);
    flag_now(f); check("R10 not yet at 5", {31'b0, f}, 32'd0);
    tick(0, 1);
    flag_now(f); check("R10 fires at 6", {31'b0, f}, 32'd1);

    // R7 write-one-to-clear, write-zero keeps
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); check("R7 write 0 keeps", r & FLAG_M, FLAG_M);
    check("R8 irq high", {31'b0, irq}, 32'd1);
    wr(A_STAT, FLAG_M);
    idle(2);
    rd(A_STAT, r); check("R7 write 1 clears", r & FLAG_M, 32'h0);
    check("R8 irq low after clear", {31'b0, irq}, 32'd0);

    // R8 masked interrupt
    wr(A_CTRL, mk(1, 1, 0, 2'd0, 0, 0));
    wr(A_THR, 32'd2);
    wait_idle("R8 idle");
    idle(10);
    tick(0, 2);
    flag_now(f); check("R8 flag with mask", {31'b0, f}, 32'd1);
    check("R8 irq masked", {31'b0, irq}, 32'd0);
    wr(A_STAT, FLAG_M);

    // R6 compare function disabled
    wr(A_CTRL, mk(1, 0, 1, 2'd0, 0, 0));
    wr(A_THR, 32'd2);
    wait_idle("R6 idle");
    idle(10);
    tick(0, 4);
    flag_now(f); check("R6 no flag when disarmed", {31'b0, f}, 32'd0);

    // R11 zero threshold
    wr(A_CTRL, mk(1, 1, 1, 2'd0, 0, 0));
    wr(A_THR, 32'd0);
    wait_idle("R11 idle");
    idle(10);
    tick(0, 20);
    flag_now(f); check("R11 zero threshold", {31'b0, f}, 32'd0);
    check("R11 irq", {31'b0, irq}, 32'd0);

    // R12 stopped counter
    wr(A_CTRL, mk(0, 1, 1, 2'd0, 0, 0));
    wr(A_THR, 32'd2);
    wait_idle("R12 idle");
    idle(10);
    tick(0, 5);
    flag_now(f); check("R12 stopped", {31'b0, f}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule